// File: doc/BRIEF.md
# Double-Buffered PWM Timer with Duty Request

This block is a single-channel up-counting PWM generator for a streaming source of duty values. One value is expected per PWM period. The counter runs from zero up to an active period value and then wraps. The wrap is the update event. The period and compare values each have a buffer register and an active register. With buffering enabled, a written value reaches the active register only at an update event.

The block raises a request strobe on either or both of two events, chosen in the control register: reaching the compare value, or the update event. An external responder answers with a one-cycle acknowledge that carries the next compare value.

The source choice matters when the responder is slow. With the request taken on the compare event, a high duty leaves only a few cycles before the wrap. The reply then misses that update, and each value is shown on two consecutive periods. With the request taken on the update event, the responder has almost a whole period, and the stream plays out one value per period.

Top module: `pwm_stream_tmr`

## Requirements
- R1: While running, the counter rises by one each clock up to the active period P, then returns to 0. The clock in which the counter equals P is the update event, so each period lasts P+1 clocks.
- R2: When control bit 1 is set, a compare value goes to the compare buffer. It becomes active at the next update event.
- R3: Address 1 holds the period. When control bit 2 is set, a new period takes effect at the next update event. When bit 2 is clear, it takes effect at once.
- R4: When control bit 1 is clear, a compare value, whether written at address 2 or carried by an acknowledge, becomes active in the next clock.
- R5: While running, pwm_o is high exactly when the counter is below the active compare value. A compare of 0 keeps pwm_o low, and a compare above P keeps it high for the whole period.
- R6: Control bit 3 raises a request on compare match (counter equals the active compare), and bit 4 raises one on the update event. req_o rises the clock after the event and holds until ack_i is high while req_o is high. That acknowledge writes ack_data_i as the new compare value, and an address-2 write in the same clock takes priority over it. An ack_i while req_o is low has no effect.
- R7: If a request event occurs while req_o is high and ack_i is low, ovr_o sets and stays set until reset.
- R8: After reset, all counter, buffer, active and control registers are zero, and req_o, ovr_o and pwm_o are low. Counting starts when control bit 0 is set, and the first clock is an update event that loads the active registers. While bit 0 is clear, pwm_o is low.
- R9: Take a period of 40 clocks, duties 20 and 36 streamed in turn, the request on the update event and a 12-clock responder. The measured high times then alternate strictly between the two values.
- R10: Take the same setup with the request on compare match. In steady state, every measured high time appears on exactly two consecutive periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address: 0 control, 1 period, 2 compare, 3 none |
| cfg_wdata_i | input | CNT_W | Register write data |
| req_o | output | 1 | Duty value request |
| ack_i | input | 1 | One-cycle acknowledge from the responder |
| ack_data_i | input | CNT_W | Compare value carried by the acknowledge |
| pwm_o | output | 1 | PWM output, active high |
| ovr_o | output | 1 | Sticky request overrun flag |

## Verification
The hardest situation to bring about is a reply landing after the update event. That is what makes a duty value repeat. It depends on where the compare value sits within the period and on the responder latency, so it cannot be set up from one register write. The bench runs a responder with a programmable delay that streams from a small circular list of duties. A 90 % duty with a 12-clock delay forces the late reply in compare-match mode, while the same list in update mode stays on time. Randomized runs then vary the period, duties (including 0 and above the period), latency and request source. A cycle model of the requirements checks req_o, ovr_o and pwm_o in every clock.

// File: rtl/pwm_stream_pkg.sv
package pwm_stream_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_PER  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CMP  = 2'd2;

  // bit 0 is run, bit 4 is request on update
  typedef struct packed {
    logic src_upd;
    logic src_cc;
    logic per_buf;
    logic cmp_buf;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_stream_shadow.sv
module pwm_stream_shadow #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         buf_en_i,
  input  logic         upd_i,
  output logic [W-1:0] pre_o,
  output logic [W-1:0] act_o
);
  logic [W-1:0] pre_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (load_i) pre_q <= val_i;
      if (load_i && !buf_en_i) act_q <= val_i;
      else if (upd_i)          act_q <= pre_q;
    end
  end

  assign pre_o = pre_q;
  assign act_o = act_q;
endmodule

// File: rtl/pwm_stream_regs.sv
module pwm_stream_regs
  import pwm_stream_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CNT_W-1:0]  cfg_wdata_i,
  input  logic              ack_wr_i,
  input  logic [CNT_W-1:0]  ack_data_i,
  input  logic              upd_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  arr_act_o,
  output logic [CNT_W-1:0]  cmp_pre_o,
  output logic [CNT_W-1:0]  cmp_act_o
);
  logic             wr_ctrl, wr_per, wr_cmp, cmp_load;
  logic [CNT_W-1:0] cmp_nxt, arr_pre_unused;
  ctrl_t            ctrl_q;
  logic             unused_wdata;

  always_comb begin
    wr_ctrl  = cfg_we_i && (cfg_addr_i == A_CTRL);
    wr_per   = cfg_we_i && (cfg_addr_i == A_PER);
    wr_cmp   = cfg_we_i && (cfg_addr_i == A_CMP);
    cmp_load = wr_cmp || ack_wr_i;
    cmp_nxt  = wr_cmp ? cfg_wdata_i : ack_data_i; // register write wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
  end

  assign unused_wdata = ^cfg_wdata_i[CNT_W-1:CTRL_W];

  pwm_stream_shadow #(.W(CNT_W)) per_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wr_per), .val_i(cfg_wdata_i),
    .buf_en_i(ctrl_q.per_buf), .upd_i(upd_i), .pre_o(arr_pre_unused), .act_o(arr_act_o)
  );

  pwm_stream_shadow #(.W(CNT_W)) cmp_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cmp_load), .val_i(cmp_nxt),
    .buf_en_i(ctrl_q.cmp_buf), .upd_i(upd_i), .pre_o(cmp_pre_o), .act_o(cmp_act_o)
  );

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/pwm_stream_cnt.sv
module pwm_stream_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] arr_act_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] cnt_q;

  assign upd_o = run_i && (cnt_q == arr_act_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= upd_o ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_stream_req.sv
module pwm_stream_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic ack_i,
  output logic req_o,
  output logic ovr_o
);
  logic req_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      req_q <= trig_i | (req_q & ~ack_i);
      ovr_q <= ovr_q | (trig_i & req_q & ~ack_i);
    end
  end

  assign req_o = req_q;
  assign ovr_o = ovr_q;
endmodule

// File: rtl/pwm_stream_tmr.sv
module pwm_stream_tmr
  import pwm_stream_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CNT_W-1:0]  cfg_wdata_i,
  output logic              req_o,
  input  logic              ack_i,
  input  logic [CNT_W-1:0]  ack_data_i,
  output logic              pwm_o,
  output logic              ovr_o
);
  ctrl_t            ctrl;
  logic             run, upd_evt, cc_evt, trig, ack_wr;
  logic [CNT_W-1:0] cnt, arr_act, cmp_pre, cmp_act;

  assign run    = ctrl.run;
  assign cc_evt = run && (cnt == cmp_act);
  assign trig   = (ctrl.src_cc && cc_evt) || (ctrl.src_upd && upd_evt);
  assign ack_wr = ack_i && req_o;
  assign pwm_o  = run && (cnt < cmp_act);

  pwm_stream_regs #(.CNT_W(CNT_W)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .ack_wr_i(ack_wr), .ack_data_i(ack_data_i),
    .upd_i(upd_evt), .ctrl_o(ctrl), .arr_act_o(arr_act), .cmp_pre_o(cmp_pre),
    .cmp_act_o(cmp_act)
  );

  pwm_stream_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .arr_act_i(arr_act),
    .cnt_o(cnt), .upd_o(upd_evt)
  );

  pwm_stream_req req_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig), .ack_i(ack_i),
    .req_o(req_o), .ovr_o(ovr_o)
  );
endmodule

// File: rtl/pwm_stream_chk.sv
module pwm_stream_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] arr_act_i,
  input logic [CNT_W-1:0] cmp_pre_i,
  input logic [CNT_W-1:0] cmp_act_i,
  input logic             cmp_buf_i,
  input logic             upd_i,
  input logic             req_i,
  input logic             ack_i,
  input logic             pwm_i,
  input logic             ovr_i
);
  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (cnt_i == arr_act_i) |=> cnt_i == '0);

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (cnt_i != arr_act_i) |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  p_cmp_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_buf_i && !upd_i |=> $stable(cmp_act_i));

  p_cmp_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_buf_i && upd_i |=> cmp_act_i == $past(cmp_pre_i));

  p_zero_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_act_i == '0 |-> !pwm_i);

  p_full_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (cmp_act_i > arr_act_i) && (cnt_i <= arr_act_i) |-> pwm_i);

  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !ack_i |=> req_i);

  p_ovr_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |=> ovr_i);

  p_idle_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !pwm_i);
endmodule

bind pwm_stream_tmr pwm_stream_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .cnt_i(cnt), .arr_act_i(arr_act),
  .cmp_pre_i(cmp_pre), .cmp_act_i(cmp_act), .cmp_buf_i(ctrl.cmp_buf), .upd_i(upd_evt),
  .req_i(req_o), .ack_i(ack_i), .pwm_i(pwm_o), .ovr_i(ovr_o)
);

// File: tb/pwm_stream_tmr_tb_top.sv
`timescale 1ns/1ps
module pwm_stream_tmr_tb_top;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic ack = 1'b0;
  logic [W-1:0] ack_data = '0;
  logic req, pwm, ovr;

  int total = 0, bad = 0, mon_total = 0, mon_bad = 0;
  bit mon_on = 0, wd_fail = 0;

  always #2.5 clk = ~clk;

  pwm_stream_tmr #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .req_o(req), .ack_i(ack), .ack_data_i(ack_data),
    .pwm_o(pwm), .ovr_o(ovr)
  );

  // ---------------- reference model of the requirements ----------------
  logic [4:0]   m_ctrl;
  logic [W-1:0] m_arr_pre, m_arr_act, m_cmp_pre, m_cmp_act, m_cnt;
  logic         m_req, m_ovr;

  always @(posedge clk or negedge rst_n) begin : mdl
    logic run_v, upd_v, cc_v, trig_v, ackw_v, cw_v, pw_v;
    logic [W-1:0] ncp;
    if (!rst_n) begin
      m_ctrl <= '0; m_arr_pre <= '0; m_arr_act <= '0; m_cmp_pre <= '0;
      m_cmp_act <= '0; m_cnt <= '0; m_req <= 1'b0; m_ovr <= 1'b0;
    end else begin
      run_v  = m_ctrl[0];
      upd_v  = run_v && (m_cnt == m_arr_act);
      cc_v   = run_v && (m_cnt == m_cmp_act);
      trig_v = (m_ctrl[3] && cc_v) || (m_ctrl[4] && upd_v);
      ackw_v = ack && m_req;
      cw_v   = cfg_we && cfg_addr == 2'd2;
      pw_v   = cfg_we && cfg_addr == 2'd1;
      ncp    = cw_v ? cfg_wdata : ack_data;
      if (cw_v || ackw_v) m_cmp_pre <= ncp;
      if ((cw_v || ackw_v) && !m_ctrl[1]) m_cmp_act <= ncp;
      else if (upd_v) m_cmp_act <= m_cmp_pre;
      if (pw_v) m_arr_pre <= cfg_wdata;
      if (pw_v && !m_ctrl[2]) m_arr_act <= cfg_wdata;
      else if (upd_v) m_arr_act <= m_arr_pre;
      if (cfg_we && cfg_addr == 2'd0) m_ctrl <= cfg_wdata[4:0];
      if (run_v) m_cnt <= upd_v ? '0 : m_cnt + 1'b1;
      m_req <= trig_v | (m_req & ~ack);
      m_ovr <= m_ovr | (trig_v & m_req & ~ack);
    end
  end

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      mon_total += 3;
      if (pwm !== (m_ctrl[0] && (m_cnt < m_cmp_act))) begin
        mon_bad++;
        $display("FAIL R1 R2 R3 R4 R5 pwm_o act=%0d exp=%0d", pwm, m_ctrl[0] && (m_cnt < m_cmp_act));
      end
      if (req !== m_req) begin
        mon_bad++; $display("FAIL R6 req_o act=%0d exp=%0d", req, m_req);
      end
      if (ovr !== m_ovr) begin
        mon_bad++; $display("FAIL R7 ovr_o act=%0d exp=%0d", ovr, m_ovr);
      end
    end
  end

  // ---------------- responder ----------------
  bit resp_on = 0;
  int lat_min = 12, lat_max = 12;
  int list_n = 2;
  logic [W-1:0] list_v [8];
  int man_cnt = 0;
  logic [W-1:0] man_data = '0;

  initial begin : responder
    int idx, wait_n, man_seen;
    bit busy;
    idx = 0; wait_n = 0; busy = 0; man_seen = 0;
    forever begin
      @(negedge clk);
      ack = 1'b0;
      if (man_cnt != man_seen) begin
        man_seen = man_cnt;
        ack = 1'b1;
        ack_data = man_data;
      end else if (!resp_on) begin
        busy = 0; idx = 0;
      end else begin
        if (!busy && req) begin
          busy = 1;
          wait_n = $urandom_range(lat_max, lat_min);
        end
        if (busy) begin
          if (wait_n == 0) begin
            ack = 1'b1;
            ack_data = list_v[idx];
            idx = (idx + 1) % list_n;
            busy = 0;
          end else wait_n--;
        end
      end
    end
  end

  // ---------------- pulse recorder ----------------
  bit rec_on = 0, rec_clr = 0;
  int hist [128];
  int hn = 0, runlen = 0;

  always @(negedge clk) begin
    if (rec_clr) begin
      hn = 0; runlen = 0;
    end else if (rec_on) begin
      if (pwm) runlen++;
      else if (runlen > 0) begin
        if (hn < 128) hist[hn] = runlen;
        hn++;
        runlen = 0;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad + int'(wd_fail));
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = W'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    @(negedge clk);
    while (m_cnt != W'(v)) @(negedge clk);
  endtask

  task automatic measure_hi(output int hi);
    int len;
    wait_cnt(0);
    len = int'(m_arr_act) + 1;
    hi = 0;
    for (int i = 0; i < len; i++) begin
      if (pwm) hi++;
      @(negedge clk);
    end
  endtask

  task automatic rise_gap(output int n);
    logic prev;
    prev = pwm; n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (pwm && !prev) break;
      prev = pwm;
    end
  endtask

  task automatic do_reset();
    resp_on = 0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic start_rec();
    rec_clr = 1; @(negedge clk); rec_clr = 0; rec_on = 1;
  endtask

  initial begin
    #(5ns * 150000);
    wd_fail = 1;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_up();
  end

  // ---------------- stimulus ----------------
  initial begin
    int hi, gap;
    void'($urandom(32'd4711));
    list_v[0] = 36; list_v[1] = 20;
    repeat (3) @(negedge clk);
    chk(pwm == 1'b0, "R8 reset pwm_o", pwm, 0);
    chk(req == 1'b0, "R8 reset req_o", req, 0);
    chk(ovr == 1'b0, "R8 reset ovr_o", ovr, 0);
    rst_n = 1'b1;
    mon_on = 1;
    repeat (4) @(negedge clk);
    chk(pwm == 1'b0, "R8 idle before run", pwm, 0);

    // ctrl bits: 0 run, 1 cmp buffer, 2 period buffer, 3 src compare, 4 src update
    cfg(2'd1, 9); cfg(2'd2, 5); cfg(2'd0, 5'b00111);
    measure_hi(hi); chk(hi == 5, "R8 R5 first update loads compare", hi, 5);

    wait_cnt(2); cfg(2'd2, 8);
    wait_cnt(6); chk(pwm == 1'b0, "R2 buffered compare not yet active", pwm, 0);
    measure_hi(hi); chk(hi == 8, "R2 compare active after update", hi, 8);

    wait_cnt(2); cfg(2'd1, 19);
    rise_gap(gap); chk(gap == 6, "R3 buffered period keeps old length", gap, 6);
    rise_gap(gap); chk(gap == 20, "R1 R3 new period length", gap, 20);

    cfg(2'd0, 5'b00101);
    wait_cnt(10); cfg(2'd2, 15);
    chk(pwm == 1'b1, "R4 unbuffered compare immediate", pwm, 1);
    cfg(2'd2, 0);
    measure_hi(hi); chk(hi == 0, "R5 compare zero stays low", hi, 0);
    cfg(2'd2, 30);
    measure_hi(hi); chk(hi == 20, "R5 compare above period stays high", hi, 20);

    cfg(2'd0, 5'b00111); cfg(2'd2, 6);
    man_data = 2; man_cnt++;
    repeat (2) @(negedge clk);
    measure_hi(hi); chk(hi == 6, "R6 ack without request ignored", hi, 6);

    cfg(2'd0, 5'b11111);
    repeat (45) @(negedge clk);
    chk(req == 1'b1, "R6 request held without ack", req, 1);
    chk(ovr == 1'b1, "R7 overrun set", ovr, 1);
    cfg(2'd0, 5'b00111);
    repeat (45) @(negedge clk);
    chk(ovr == 1'b1, "R7 overrun sticky", ovr, 1);
    do_reset();
    @(negedge clk);
    chk(ovr == 1'b0 && req == 1'b0, "R8 reset clears flags", {ovr, req}, 0);

    // R9: update-sourced requests
    list_v[0] = 36; list_v[1] = 20; list_n = 2; lat_min = 12; lat_max = 12;
    cfg(2'd1, 39); cfg(2'd2, 20);
    resp_on = 1;
    cfg(2'd0, 5'b10111);
    start_rec();
    repeat (1200) @(negedge clk);
    rec_on = 0;
    chk(hn >= 20, "R9 pulse count", hn, 20);
    for (int k = 3; k < hn - 1 && k < 127; k++) begin
      chk((hist[k] == 20 || hist[k] == 36) && hist[k] != hist[k+1],
          "R9 strict alternation", hist[k+1], hist[k] == 20 ? 36 : 20);
    end
    do_reset();

    // R10: compare-sourced requests, late replies repeat a duty
    cfg(2'd1, 39); cfg(2'd2, 20);
    resp_on = 1;
    cfg(2'd0, 5'b01111);
    start_rec();
    repeat (1200) @(negedge clk);
    rec_on = 0;
    begin
      int g [64];
      int gn, len, cur;
      gn = 0; len = 1; cur = hist[2];
      for (int k = 3; k < hn && k < 128; k++) begin
        if (hist[k] == cur) len++;
        else begin
          if (gn < 64) g[gn] = len;
          gn++; cur = hist[k]; len = 1;
        end
      end
      chk(gn >= 6, "R10 group count", gn, 6);
      for (int j = 1; j < gn && j < 64; j++)
        chk(g[j] == 2, "R10 each duty twice", g[j], 2);
    end
    do_reset();

    // randomized runs
    for (int t = 0; t < 8; t++) begin
      int per, c;
      per = $urandom_range(40, 20);
      list_n = $urandom_range(4, 1);
      for (int i = 0; i < 8; i++) list_v[i] = W'($urandom_range(45, 0));
      lat_min = 0; lat_max = $urandom_range(30, 0);
      c = 5'b00101 | ($urandom_range(1, 0) << 1) | ($urandom_range(3, 0) << 3);
      cfg(2'd1, per); cfg(2'd2, $urandom_range(45, 0));
      resp_on = 1;
      cfg(2'd0, c);
      for (int s = 0; s < 4; s++) begin
        repeat ($urandom_range(150, 50)) @(negedge clk);
        cfg(2'd2, $urandom_range(45, 0));
      end
      repeat (100) @(negedge clk);
      chk(1'b1, "R1 R2 R4 R6 R7 random run done", t, t);
      do_reset();
    end

    mon_on = 0;
    finish_up();
  end
endmodule